// File: doc/BRIEF.md
# Configurable Serial Line Port

This block drives and receives one serial line through a five-pin port whose pin roles depend on a two-bit mode select. In the single-ended and differential modes it codes each byte with Differential Manchester coding. The receiver recovers the cell timing from the line transitions and reports a code violation when the timing breaks. The single-ended mode also raises an enable pin for an external transceiver while a frame is sent. In the raw mode the block does no line coding. It sends plain bits together with a bit clock and a frame clock, and it takes plain bits back from an external transceiver that codes the line itself.

Bytes enter through a valid/ready pair and leave as a one-cycle valid pulse. Each frame is eight bits, least significant bit first, and every bit cell lasts `CPB` clocks. A digital pulse filter with four settings sits on every receive input. It accepts a new level only after that level has held for a set number of clocks. Setting 0 is the one to use at high bit rates, where a longer filter would remove real half cells.

Top module: `sline_port`

## Requirements
- R1: During reset and in mode 0, `pin_o` is all zero, `pin_oe_o` is 5'b00110, `tx_ready_o` is 1, and `rx_valid_o` and `rx_err_o` are 0.
- R2: Mode 0 is single-ended, and the unused code 3 behaves the same way. Pin 1 carries the coded line and pin 2 is the transceiver enable. The enable is high for exactly 8*CPB cycles, starting at the clock edge that accepts the byte. `pin_oe_o` is 5'b00110 and pin 0 is the receive input.
- R3: The coded line changes level at every cell boundary. This includes the first boundary, at the accepting edge, and a closing boundary 8*CPB cycles later. A 0 bit adds one more change CPB/2 cycles into its cell, and a 1 bit adds none. Bits are sent least significant bit first.
- R4: Mode 1 is differential. Pins 2 and 3 carry the coded line and its complement, and `pin_oe_o` is 5'b01100. The receive level follows pin 0 while pins 0 and 1 differ, and it keeps its last value while they are equal.
- R5: Mode 2 is raw. Pin 1 holds bit i, least significant bit first, for cycles i*CPB to i*CPB+CPB-1, counted from the accepting edge. Pin 2 is high in the first CPB/2 cycles of each cell. Pin 4 is high for the 8*CPB frame cycles. `pin_oe_o` is 5'b10110, and all these pins are 0 when the block is idle.
- R6: In modes 0 and 1, the receiver decodes a received Differential Manchester frame. On the closing boundary it gives a one-cycle `rx_valid_o` pulse with the byte on `rx_data_o`.
- R7: The receiver pulses `rx_err_o` and drops the frame in three cases. The first is a change in the first CPB/4 cycles of a cell. The second is a second mid-cell change in the same cell. The third is a cell with no boundary change within CPB+CPB/4 cycles. `rx_valid_o` and `rx_err_o` are never high together.
- R8: In mode 2, a rising edge on pin 3 starts a received frame. Pin 0 is sampled CPB/2 cycles into each of eight cells, and the byte is then given as in R6.
- R9: `filt_sel_i` values 0, 1, 2 and 3 need a receive input to hold a new level for 1, 5, 10 or 20 times `FILT_UNIT` clocks before the level is accepted. A shorter pulse is ignored.
- R10: `tx_ready_o` is low from the accepting edge until the frame ends. `tx_valid_i` has no effect on the line while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 0 single-ended, 1 differential, 2 raw, 3 same as 0 |
| filt_sel_i | input | 2 | Receive filter setting |
| tx_data_i | input | 8 | Byte to send |
| tx_valid_i | input | 1 | Byte to send is valid |
| tx_ready_o | output | 1 | Transmitter idle, byte accepted on valid |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | One-cycle pulse, received byte valid |
| rx_err_o | output | 1 | One-cycle pulse, code violation |
| pin_i | input | 5 | Port pin input levels |
| pin_o | output | 5 | Port pin output levels |
| pin_oe_o | output | 5 | Port pin output enables |

## Verification
The transmit waveform is compared cycle by cycle, in every mode, against a level computed from the byte. The bytes 0x00, 0xFF, 0xA5 and 0x3C separate missing mid-cell changes, extra mid-cell changes, bit order errors and missing boundary changes. In loopback, each mode's output pins feed its input pins, so encoder and decoder are tried together with mixed, all-zero and all-one bytes. Driven pulses just below and at each tested filter length show whether the filter threshold is placed correctly. A single edge and two equal differential inputs show the timeout violation and the hold rule at the ports.

// File: rtl/sline_pkg.sv
package sline_pkg;
  typedef enum logic [1:0] {
    MODE_SE   = 2'd0,
    MODE_DIFF = 2'd1,
    MODE_RAW  = 2'd2,
    MODE_RSVD = 2'd3
  } mode_e;

  // filter length multiples per setting
  localparam int unsigned FILT_MULT [4] = '{1, 5, 10, 20};
endpackage

// File: rtl/sline_filt.sv
module sline_filt
  import sline_pkg::*;
#(
  parameter int unsigned UNIT = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] sel_i,
  input  logic       d_i,
  output logic       q_o
);
  localparam int unsigned MAXN = FILT_MULT[3] * UNIT;
  localparam int unsigned CW   = $clog2(MAXN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q, lim;
  logic          q_q;

  always_comb lim = CW'(FILT_MULT[sel_i] * UNIT - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      cnt_q  <= '0;
      q_q    <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], d_i};
      if (sync_q[1] == q_q) cnt_q <= '0;
      else if (cnt_q >= lim) begin
        q_q   <= sync_q[1];
        cnt_q <= '0;
      end else cnt_q <= cnt_q + CW'(1);
    end
  end

  assign q_o = q_q;

  AST_FILT_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_q != $past(q_q)) |-> ($past(sync_q[1]) != $past(q_q))); // R9
endmodule

// File: rtl/sline_tx.sv
module sline_tx #(
  parameter int unsigned CPB = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] data_i,
  input  logic       valid_i,
  output logic       ready_o,
  output logic       line_o,
  output logic       busy_o,
  output logic       bit_o,
  output logic       first_half_o
);
  localparam int unsigned CW   = $clog2(CPB);
  localparam int unsigned HALF = CPB / 2;

  logic          busy_q, line_q;
  logic [CW-1:0] cnt_q;
  logic [2:0]    idx_q;
  logic [7:0]    sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      line_q <= 1'b0;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
    end else if (!busy_q) begin
      if (valid_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        idx_q  <= '0;
        sh_q   <= data_i;
        line_q <= ~line_q;  // first boundary
      end
    end else begin
      cnt_q <= (cnt_q == CW'(CPB - 1)) ? '0 : cnt_q + CW'(1);
      if (cnt_q == CW'(HALF - 1) && !sh_q[0]) line_q <= ~line_q;
      if (cnt_q == CW'(CPB - 1)) begin
        line_q <= ~line_q;  // next or closing boundary
        sh_q   <= sh_q >> 1;
        idx_q  <= idx_q + 3'd1;
        if (idx_q == 3'd7) busy_q <= 1'b0;
      end
    end
  end

  assign ready_o      = ~busy_q;
  assign line_o       = line_q;
  assign busy_o       = busy_q;
  assign bit_o        = busy_q & sh_q[0];
  assign first_half_o = busy_q && (cnt_q < CW'(HALF));

  AST_TX_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !$past(busy_q)) |-> $past(valid_i)); // R10
  AST_TX_LINE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_q != $past(line_q)) |-> ($past(busy_q) || $past(valid_i))); // R3
endmodule

// File: rtl/sline_rx.sv
module sline_rx #(
  parameter int unsigned CPB = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       raw_i,
  input  logic       d_i,
  input  logic       strb_i,
  output logic [7:0] data_o,
  output logic       valid_o,
  output logic       err_o
);
  localparam int unsigned QTR  = CPB / 4;
  localparam int unsigned HALF = CPB / 2;
  localparam int unsigned TMO  = CPB + QTR;
  localparam int unsigned CW   = $clog2(TMO + 2);

  logic          d_q, s_q, act_q, mid_q, valid_q, err_q;
  logic [CW-1:0] cnt_q;
  logic [2:0]    idx_q;
  logic [7:0]    sh_q, data_q;
  logic          chg, srise;

  assign chg   = d_i ^ d_q;
  assign srise = strb_i & ~s_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_q <= 1'b0; s_q <= 1'b0; act_q <= 1'b0; mid_q <= 1'b0;
      valid_q <= 1'b0; err_q <= 1'b0;
      cnt_q <= '0; idx_q <= '0; sh_q <= '0; data_q <= '0;
    end else begin
      d_q     <= d_i;
      s_q     <= strb_i;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      if (raw_i) begin
        if (!act_q) begin
          if (srise) begin
            act_q <= 1'b1; cnt_q <= CW'(1); idx_q <= '0;
          end
        end else begin
          cnt_q <= (cnt_q == CW'(CPB - 1)) ? '0 : cnt_q + CW'(1);
          if (cnt_q == CW'(HALF)) begin
            sh_q  <= {d_i, sh_q[7:1]};
            idx_q <= idx_q + 3'd1;
            if (idx_q == 3'd7) begin
              act_q <= 1'b0; valid_q <= 1'b1; data_q <= {d_i, sh_q[7:1]};
            end
          end
        end
      end else if (!act_q) begin
        if (chg) begin
          act_q <= 1'b1; cnt_q <= CW'(1); idx_q <= '0; mid_q <= 1'b0;
        end
      end else if (chg) begin
        if (cnt_q < CW'(QTR) || (cnt_q < CW'(HALF + QTR) && mid_q)) begin
          act_q <= 1'b0; err_q <= 1'b1;
        end else if (cnt_q < CW'(HALF + QTR)) begin
          mid_q <= 1'b1; cnt_q <= cnt_q + CW'(1);
        end else begin
          sh_q  <= {~mid_q, sh_q[7:1]};
          mid_q <= 1'b0;
          cnt_q <= CW'(1);
          idx_q <= idx_q + 3'd1;
          if (idx_q == 3'd7) begin
            act_q <= 1'b0; valid_q <= 1'b1; data_q <= {~mid_q, sh_q[7:1]};
          end
        end
      end else if (cnt_q >= CW'(TMO)) begin
        act_q <= 1'b0; err_q <= 1'b1;
      end else cnt_q <= cnt_q + CW'(1);
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;
  assign err_o   = err_q;

  AST_RX_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_q && err_q)); // R7
  AST_RX_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(TMO)); // R7
endmodule

// File: rtl/sline_port.sv
module sline_port
  import sline_pkg::*;
#(
  parameter int unsigned CPB       = 16,
  parameter int unsigned FILT_UNIT = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic [1:0] filt_sel_i,
  input  logic [7:0] tx_data_i,
  input  logic       tx_valid_i,
  output logic       tx_ready_o,
  output logic [7:0] rx_data_o,
  output logic       rx_valid_o,
  output logic       rx_err_o,
  input  logic [4:0] pin_i,
  output logic [4:0] pin_o,
  output logic [4:0] pin_oe_o
);
  mode_e mode;
  assign mode = mode_e'(mode_i);

  logic line, busy, tbit, first_half;
  logic diff_lvl_q;
  logic [1:0] src, filt;

  sline_tx #(.CPB(CPB)) u_tx (
    .clk_i, .rst_ni,
    .data_i(tx_data_i), .valid_i(tx_valid_i), .ready_o(tx_ready_o),
    .line_o(line), .busy_o(busy), .bit_o(tbit), .first_half_o(first_half)
  );

  // equal differential inputs keep the last decided level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) diff_lvl_q <= 1'b0;
    else if (pin_i[0] != pin_i[1]) diff_lvl_q <= pin_i[0];
  end

  assign src[0] = (mode == MODE_DIFF) ? diff_lvl_q : pin_i[0];
  assign src[1] = pin_i[3];

  for (genvar g = 0; g < 2; g++) begin : g_filt
    sline_filt #(.UNIT(FILT_UNIT)) u_filt (
      .clk_i, .rst_ni, .sel_i(filt_sel_i), .d_i(src[g]), .q_o(filt[g])
    );
  end

  sline_rx #(.CPB(CPB)) u_rx (
    .clk_i, .rst_ni,
    .raw_i(mode == MODE_RAW), .d_i(filt[0]), .strb_i(filt[1]),
    .data_o(rx_data_o), .valid_o(rx_valid_o), .err_o(rx_err_o)
  );

  always_comb begin
    case (mode)
      MODE_DIFF: begin
        pin_o    = {1'b0, ~line, line, 2'b00};
        pin_oe_o = 5'b01100;
      end
      MODE_RAW: begin
        pin_o    = {busy, 1'b0, first_half, tbit, 1'b0};
        pin_oe_o = 5'b10110;
      end
      default: begin
        pin_o    = {2'b00, busy, line, 1'b0};
        pin_oe_o = 5'b00110;
      end
    endcase
  end

  AST_DIFF_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_DIFF) |-> (pin_o[3] != pin_o[2])); // R4
endmodule

// File: tb/tb_sline_port.sv
module tb_sline_port;
  localparam int C = 16;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] mode_i = 2'd0, filt_sel_i = 2'd0;
  logic [7:0] tx_data_i = 8'h00;
  logic       tx_valid_i = 1'b0;
  logic       tx_ready_o, rx_valid_o, rx_err_o;
  logic [7:0] rx_data_o;
  logic [4:0] pin_i, pin_o, pin_oe_o;
  logic [4:0] man = 5'b0;
  logic [1:0] lb = 2'd0;

  int nchk = 0, nerr = 0, cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  always_comb begin
    case (lb)
      2'd1:    pin_i = {4'b0000, pin_o[1]};
      2'd2:    pin_i = {3'b000, pin_o[3], pin_o[2]};
      2'd3:    pin_i = {1'b0, pin_o[4], 2'b00, pin_o[1]};
      default: pin_i = man;
    endcase
  end

  sline_port #(.CPB(C), .FILT_UNIT(1)) dut (
    .clk_i(clk), .rst_ni, .mode_i, .filt_sel_i, .tx_data_i, .tx_valid_i,
    .tx_ready_o, .rx_data_o, .rx_valid_o, .rx_err_o, .pin_i, .pin_o, .pin_oe_o
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int tog(input logic [7:0] b, input int j);
    int t;
    if (j >= 8 * C) begin
      t = 9;
      for (int i = 0; i < 8; i++) if (!b[i]) t++;
      return t;
    end
    t = 1 + j / C;
    for (int i = 0; i < j / C; i++) if (!b[i]) t++;
    if (!b[j / C] && (j % C) >= C / 2) t++;
    return t;
  endfunction

  task automatic settle();
    repeat (4 * C) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(pin_o == 5'b0, "R1", "pin_o in reset", int'(pin_o), 0);
    chk(pin_oe_o == 5'b00110, "R1", "pin_oe_o in reset", int'(pin_oe_o), 6);
    chk(tx_ready_o && !rx_valid_o && !rx_err_o, "R1", "ready/valid/err in reset",
        int'({tx_ready_o, rx_valid_o, rx_err_o}), 4);
    rst_ni = 1'b1;
  endtask

  // transmit waveform check, one frame, manual pins
  task automatic tx_frame(input logic [1:0] m, input logic [7:0] b);
    int bad, fj, fa, fe, rbad;
    logic ln0, exp_l;
    logic [4:0] oe_exp, act, expv;
    lb = 2'd0; man = 5'b0; mode_i = m;
    settle();
    oe_exp = (m == 2'd1) ? 5'b01100 : (m == 2'd2) ? 5'b10110 : 5'b00110;
    chk(pin_oe_o == oe_exp, (m == 2'd2) ? "R5" : (m == 2'd1) ? "R4" : "R2",
        "output enables", int'(pin_oe_o), int'(oe_exp));
    ln0 = (m == 2'd1) ? pin_o[2] : pin_o[1];
    tx_data_i = b; tx_valid_i = 1'b1;
    bad = 0; rbad = 0; fj = -1; fa = 0; fe = 0;
    for (int j = 0; j <= 8 * C; j++) begin
      @(negedge clk);
      if (j == 0) tx_valid_i = 1'b0;
      exp_l = ln0 ^ tog(b, j)[0];
      if (m == 2'd2)
        expv = (j < 8 * C) ? {1'b1, 1'b0, (j % C) < C / 2, b[j / C], 1'b0} : 5'b0;
      else if (m == 2'd1)
        expv = {1'b0, ~exp_l, exp_l, 2'b00};
      else
        expv = {2'b00, j < 8 * C, exp_l, 1'b0};
      act = pin_o;
      if (act != expv) begin
        bad++;
        if (fj < 0) begin fj = j; fa = int'(act); fe = int'(expv); end
      end
      if (tx_ready_o != (j == 8 * C)) rbad++;
      if (j == C) begin tx_data_i = ~b; tx_valid_i = 1'b1; end  // while busy
      if (j == C + 2) tx_valid_i = 1'b0;
    end
    if (m == 2'd2) chk(bad == 0, "R5", $sformatf("raw pins, first bad cycle %0d", fj), fa, fe);
    else if (m == 2'd1) chk(bad == 0, "R4/R3", $sformatf("diff pins, first bad cycle %0d", fj), fa, fe);
    else chk(bad == 0, "R2/R3", $sformatf("single-ended pins, first bad cycle %0d", fj), fa, fe);
    chk(rbad == 0, "R10", "ready low only during frame, valid ignored", rbad, 0);
  endtask

  task automatic rx_loop(input logic [1:0] m, input logic [1:0] f, input logic [7:0] b,
                         input string req);
    bit got, err;
    logic [7:0] d;
    mode_i = m; filt_sel_i = f;
    lb = (m == 2'd1) ? 2'd2 : (m == 2'd2) ? 2'd3 : 2'd1;
    settle();
    tx_data_i = b; tx_valid_i = 1'b1;
    @(negedge clk); tx_valid_i = 1'b0;
    got = 0; err = 0; d = 8'h00;
    for (int k = 0; k < 12 * C && !got && !err; k++) begin
      @(negedge clk);
      if (rx_valid_o) begin got = 1; d = rx_data_o; end
      if (rx_err_o) err = 1;
    end
    chk(got && !err, req, "frame received without violation", int'({got, err}), 2);
    chk(d == b, req, "received byte", int'(d), int'(b));
    lb = 2'd0; man = 5'b0; filt_sel_i = 2'd0;
  endtask

  task automatic watch_err(input int n, output bit e, output bit v);
    e = 0; v = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (rx_err_o) e = 1;
      if (rx_valid_o) v = 1;
    end
  endtask

  task automatic t_violation();
    bit e1, v1, e2, v2;
    mode_i = 2'd0; filt_sel_i = 2'd0; lb = 2'd0; man = 5'b0;
    settle();
    man[0] = 1'b1;  // single boundary, then nothing
    watch_err(C, e1, v1);
    chk(!e1, "R7", "no violation before a cell has elapsed", int'(e1), 0);
    watch_err(2 * C, e2, v2);
    chk(e2 && !v1 && !v2, "R7", "missing boundary flagged, no byte", int'({e2, v1 | v2}), 2);
    man[0] = 1'b0;
    settle();
  endtask

  task automatic t_glitch(input logic [1:0] f, input int w, input bit exp_err);
    bit e, v;
    mode_i = 2'd0; filt_sel_i = f; lb = 2'd0; man = 5'b0;
    settle();
    man[0] = 1'b1;
    repeat (w) @(negedge clk);
    man[0] = 1'b0;
    watch_err(4 * C, e, v);
    chk(e == exp_err && !v, "R9", $sformatf("filter %0d pulse of %0d clocks", f, w),
        int'(e), int'(exp_err));
    settle();
    filt_sel_i = 2'd0;
  endtask

  task automatic t_diff_hold();
    bit e, v;
    mode_i = 2'd1; filt_sel_i = 2'd0; lb = 2'd0; man = 5'b00010;  // low
    settle();
    man = 5'b00011;  // equal pins: level held
    watch_err(3 * C, e, v);
    chk(!e && !v, "R4", "equal differential inputs keep level", int'(e), 0);
    man = 5'b00001;  // high: one edge, then timeout
    watch_err(3 * C, e, v);
    chk(e, "R4", "differential high seen as edge", int'(e), 1);
    man = 5'b00010;
    settle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    tx_frame(2'd0, 8'hA5);
    tx_frame(2'd0, 8'h00);
    tx_frame(2'd3, 8'h0F);
    tx_frame(2'd1, 8'hFF);
    tx_frame(2'd1, 8'h3C);
    tx_frame(2'd2, 8'h96);
    tx_frame(2'd2, 8'h01);
    rx_loop(2'd0, 2'd0, 8'h5A, "R6");
    rx_loop(2'd0, 2'd1, 8'h00, "R6");
    rx_loop(2'd1, 2'd0, 8'hFF, "R6");
    rx_loop(2'd1, 2'd0, 8'hC3, "R6");
    rx_loop(2'd2, 2'd1, 8'h6B, "R8");
    rx_loop(2'd2, 2'd0, 8'h80, "R8");
    t_violation();
    t_glitch(2'd0, 1, 1'b1);
    t_glitch(2'd1, 4, 1'b0);
    t_glitch(2'd1, 5, 1'b1);
    t_glitch(2'd3, 19, 1'b0);
    t_glitch(2'd3, 20, 1'b1);
    t_diff_hold();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      nchk++; nerr++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule